// File: doc/BRIEF.md
# Local interrupt vector dispatcher

This block sits beside a processor core. It turns the core's three local interrupt sources into requests the core can act on. The sources are a timer tick and two external interrupt pins, called pin A and pin B in this text. Each source owns a 32-bit routing entry. When a source fires, the block looks up that entry. If the entry is masked, the event is dropped. Otherwise the entry's delivery mode decides the result: a pulse on the system-management or non-maskable request line, a sticky external-controller request, or a vector number posted into a 256-bit pending register with a matching per-vector trigger flag.

Software loads the entries through a one-cycle write port. A falling edge on pin A can withdraw a request that a level-sensitive pin A entry raised earlier. All three sources are evaluated on every clock, each through its own path. Arbitration among pending vectors, acknowledge and end-of-interrupt are left to logic downstream of the pending and trigger vectors.

Top module: `lvd_dispatch`

## Requirements
- R1: When an entry has its mask bit (bit 16) set and its source fires, smi_req and nmi_req stay low, ext_req does not change and no pending or trigger bit changes.
- R2: The delivery mode is entry bits 10:8. 3'b000 is fixed, 3'b010 is system management, 3'b100 is non-maskable and 3'b111 is external controller. A source whose entry holds any other code produces no output.
- R3: When an unmasked source in system-management mode fires, smi_req is high for exactly the next cycle. In non-maskable mode, nmi_req behaves the same way. Neither mode posts a vector.
- R4: When an unmasked source in external-controller mode fires, ext_req is set from the next cycle on. It stays high until a pin A fall clears it (R7, R8) or reset. No vector is posted.
- R5: When an unmasked source in fixed mode fires, pending bit number entry[7:0] is set from the next cycle on. Pending bits stay set until cleared by R7 or reset.
- R6: Each fixed-mode posting also writes the trigger bit of the same vector. It writes 1 (level) only when the source is pin A or pin B and entry bit 15 is set. Otherwise it writes 0 (edge). A timer posting always writes 0.
- R7: When pin A falls and its entry is fixed mode with bit 15 set, the pending bit of that entry's vector is cleared and ext_req is cleared, whatever the mask bit holds.
- R8: When pin A falls and its entry is in external-controller mode, ext_req is cleared. A pin A fall with a fixed, edge-triggered entry changes nothing.
- R9: After reset, all outputs are 0. In the bootstrap configuration, the pin A entry holds 32'h0000_0700 (external-controller mode, unmasked). Every other entry holds 32'h0001_0000 (masked).
- R10: Events from all three sources in the same cycle are all applied. If two postings hit the same vector, the trigger bit is 1 when either posting is level. A set in the same cycle as an R7 or R8 clear wins over the clear.
- R11: Pins A and B fire only on a rising edge; a pin held high fires once. The timer fires on every cycle in which tmr_fire is high. An entry write takes effect on the next cycle, so an event in the write cycle uses the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Entry write strobe |
| cfg_sel | input | 2 | Entry select: 0 timer, 1 pin A, 2 pin B |
| cfg_wdata | input | ENTRY_W (32) | Entry write data |
| tmr_fire | input | 1 | Timer event, one per high cycle |
| lint0_pin | input | 1 | External pin A level |
| lint1_pin | input | 1 | External pin B level |
| smi_req | output | 1 | System-management request pulse |
| nmi_req | output | 1 | Non-maskable request pulse |
| ext_req | output | 1 | External-controller request, sticky |
| pend_vec | output | 2**VEC_W (256) | Pending vector bits |
| trig_vec | output | 2**VEC_W (256) | Trigger flag per vector, 1 = level |

## Verification
The bound checker tests cycle-local rules on every cycle:
- The timer's fixed, system-management and masked outcomes, including the edge flag it must record.
- The non-maskable pulse that pin B produces.
- That a system-management pulse never appears without a source event.
- The two pin A withdrawal cases.

Cross-source behaviour is shown only by the bench scenarios: same-vector collisions, a set overriding a clear, the order of an entry write against an event, and the one-shot nature of a held pin. The bench compares every output each cycle against a model that tracks the entries.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
   localparam int unsigned NUM_SRC   = 3;
   localparam int unsigned SEL_W     = 2;
   localparam int unsigned SRC_TMR   = 0;
   localparam int unsigned SRC_PINA  = 1;
   localparam int unsigned SRC_PINB  = 2;
   localparam int unsigned MASK_BIT  = 16;
   localparam int unsigned LVL_BIT   = 15;
   localparam int unsigned MODE_LSB  = 8;
   localparam int unsigned MODE_W    = 3;

   typedef enum logic [MODE_W-1:0] {
      DM_FIXED  = 3'b000,
      DM_SMI    = 3'b010,
      DM_NMI    = 3'b100,
      DM_EXTCTL = 3'b111
   } dmode_e;

   typedef struct packed {
      logic smi;
      logic nmi;
      logic ext;
   } req_t;
endpackage

// File: rtl/lvd_entry_regs.sv
module lvd_entry_regs
   import lvd_pkg::*;
#(
   parameter int unsigned ENTRY_W = 32,
   parameter bit          IS_BSP  = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [SEL_W-1:0]                  sel,
   input  logic [ENTRY_W-1:0]                wdata,
   output logic [NUM_SRC-1:0][ENTRY_W-1:0]   entry
);
   localparam logic [ENTRY_W-1:0] MASKED_RST = ENTRY_W'(1) << MASK_BIT;
   localparam logic [ENTRY_W-1:0] PINA_RST   = ENTRY_W'({DM_EXTCTL, 8'h00});

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_entry
      localparam logic [ENTRY_W-1:0] RST_VAL =
         (i == SRC_PINA && IS_BSP) ? PINA_RST : MASKED_RST;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            entry[i] <= RST_VAL;
         end else if (we && sel == SEL_W'(i)) begin
            entry[i] <= wdata;
         end
      end
   end
endmodule

// File: rtl/lvd_src_decode.sv
module lvd_src_decode
   import lvd_pkg::*;
#(
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned ENTRY_W = 32,
   parameter bit          HAS_LVL = 1'b0
) (
   input  logic               fire,
   input  logic [ENTRY_W-1:0] entry,
   output logic               post,
   output logic [VEC_W-1:0]   vec,
   output logic               lvl,
   output req_t               req
);
   logic                active;
   logic [MODE_W-1:0]   mode;
   logic                unused_bits;

   assign unused_bits = ^entry;
   assign active = fire & ~entry[MASK_BIT];
   assign mode   = entry[MODE_LSB +: MODE_W];
   assign vec    = entry[VEC_W-1:0];

   if (HAS_LVL) begin : g_lvl
      assign lvl = entry[LVL_BIT];
   end else begin : g_edge
      assign lvl = 1'b0;
   end

   always_comb begin
      post = 1'b0;
      req  = '0;
      if (active) begin
         case (mode)
            DM_FIXED:  post    = 1'b1;
            DM_SMI:    req.smi = 1'b1;
            DM_NMI:    req.nmi = 1'b1;
            DM_EXTCTL: req.ext = 1'b1;
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/lvd_pend_array.sv
module lvd_pend_array
   import lvd_pkg::*;
#(
   parameter int unsigned VEC_W = 8,
   localparam int unsigned NVEC = 1 << VEC_W
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_SRC-1:0]              post,
   input  logic [NUM_SRC-1:0][VEC_W-1:0]   vec,
   input  logic [NUM_SRC-1:0]              lvl,
   input  logic                            clr,
   input  logic [VEC_W-1:0]                clr_vec,
   output logic [NVEC-1:0]                 pend,
   output logic [NVEC-1:0]                 trig
);
   for (genvar b = 0; b < NVEC; b++) begin : g_bit
      logic set_hit;
      logic lvl_hit;

      always_comb begin
         set_hit = 1'b0;
         lvl_hit = 1'b0;
         for (int s = 0; s < NUM_SRC; s++) begin
            if (post[s] && vec[s] == VEC_W'(b)) begin
               set_hit = 1'b1;
               lvl_hit = lvl_hit | lvl[s];
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[b] <= 1'b0;
            trig[b] <= 1'b0;
         end else if (set_hit) begin
            pend[b] <= 1'b1;
            trig[b] <= lvl_hit;
         end else if (clr && clr_vec == VEC_W'(b)) begin
            pend[b] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lvd_dispatch.sv
module lvd_dispatch
   import lvd_pkg::*;
#(
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned ENTRY_W = 32,
   parameter bit          IS_BSP  = 1'b1,
   localparam int unsigned NVEC   = 1 << VEC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [SEL_W-1:0]   cfg_sel,
   input  logic [ENTRY_W-1:0] cfg_wdata,
   input  logic               tmr_fire,
   input  logic               lint0_pin,
   input  logic               lint1_pin,
   output logic               smi_req,
   output logic               nmi_req,
   output logic               ext_req,
   output logic [NVEC-1:0]    pend_vec,
   output logic [NVEC-1:0]    trig_vec
);
   if (VEC_W < 1 || VEC_W > 8) begin : g_bad_vec
      $error("lvd_dispatch: VEC_W must lie in 1..8");
   end
   if (ENTRY_W <= MASK_BIT) begin : g_bad_entry
      $error("lvd_dispatch: ENTRY_W too narrow for the mask bit");
   end

   logic [NUM_SRC-1:0][ENTRY_W-1:0] entry_q;
   logic                            pina_q, pinb_q;
   logic                            pina_rise, pina_fall, pinb_rise;
   logic [NUM_SRC-1:0]              fire;
   logic [NUM_SRC-1:0]              post;
   logic [NUM_SRC-1:0][VEC_W-1:0]   vec;
   logic [NUM_SRC-1:0]              lvl;
   req_t [NUM_SRC-1:0]              req;
   logic                            any_smi, any_nmi, any_ext;
   logic [MODE_W-1:0]               pina_mode;
   logic                            pina_fixlvl, drop_ext, clr_pend;

   lvd_entry_regs #(.ENTRY_W(ENTRY_W), .IS_BSP(IS_BSP)) u_entries (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .sel   (cfg_sel),
      .wdata (cfg_wdata),
      .entry (entry_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pina_q <= 1'b0;
         pinb_q <= 1'b0;
      end else begin
         pina_q <= lint0_pin;
         pinb_q <= lint1_pin;
      end
   end

   assign pina_rise = lint0_pin & ~pina_q;
   assign pina_fall = ~lint0_pin & pina_q;
   assign pinb_rise = lint1_pin & ~pinb_q;

   assign fire[SRC_TMR]  = tmr_fire;
   assign fire[SRC_PINA] = pina_rise;
   assign fire[SRC_PINB] = pinb_rise;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      lvd_src_decode #(
         .VEC_W   (VEC_W),
         .ENTRY_W (ENTRY_W),
         .HAS_LVL (i != SRC_TMR)
      ) u_dec (
         .fire  (fire[i]),
         .entry (entry_q[i]),
         .post  (post[i]),
         .vec   (vec[i]),
         .lvl   (lvl[i]),
         .req   (req[i])
      );
   end

   always_comb begin
      any_smi = 1'b0;
      any_nmi = 1'b0;
      any_ext = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
         any_smi = any_smi | req[s].smi;
         any_nmi = any_nmi | req[s].nmi;
         any_ext = any_ext | req[s].ext;
      end
   end

   // Pin A withdrawal ignores the mask bit on purpose.
   assign pina_mode   = entry_q[SRC_PINA][MODE_LSB +: MODE_W];
   assign pina_fixlvl = (pina_mode == DM_FIXED) && entry_q[SRC_PINA][LVL_BIT];
   assign clr_pend    = pina_fall & pina_fixlvl;
   assign drop_ext    = pina_fall & (pina_fixlvl | (pina_mode == DM_EXTCTL));

   lvd_pend_array #(.VEC_W(VEC_W)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .post    (post),
      .vec     (vec),
      .lvl     (lvl),
      .clr     (clr_pend),
      .clr_vec (vec[SRC_PINA]),
      .pend    (pend_vec),
      .trig    (trig_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smi_req <= 1'b0;
         nmi_req <= 1'b0;
         ext_req <= 1'b0;
      end else begin
         smi_req <= any_smi;
         nmi_req <= any_nmi;
         if (any_ext) begin
            ext_req <= 1'b1;
         end else if (drop_ext) begin
            ext_req <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lvd_checker.sv
module lvd_checker
   import lvd_pkg::*;
#(
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned ENTRY_W = 32,
   localparam int unsigned NVEC   = 1 << VEC_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tmr_fire,
   input logic               rise_a,
   input logic               fall_a,
   input logic               rise_b,
   input logic [ENTRY_W-1:0] e_tmr,
   input logic [ENTRY_W-1:0] e_pina,
   input logic [ENTRY_W-1:0] e_pinb,
   input logic               smi_req,
   input logic               nmi_req,
   input logic               ext_req,
   input logic [NVEC-1:0]    pend_vec,
   input logic [NVEC-1:0]    trig_vec
);
   logic              t_live, a_live, b_live;
   logic [MODE_W-1:0] t_mode, a_mode, b_mode;

   assign t_live = ~e_tmr[MASK_BIT];
   assign a_live = ~e_pina[MASK_BIT];
   assign b_live = ~e_pinb[MASK_BIT];
   assign t_mode = e_tmr[MODE_LSB +: MODE_W];
   assign a_mode = e_pina[MODE_LSB +: MODE_W];
   assign b_mode = e_pinb[MODE_LSB +: MODE_W];

   assert_masked_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_fire && !t_live && !rise_a && !rise_b && !fall_a)
      |=> ($stable(pend_vec) && !smi_req && !nmi_req && $stable(ext_req)));

   assert_smi_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_fire && t_live && t_mode == DM_SMI) |=> smi_req);

   assert_nmi_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_b && b_live && b_mode == DM_NMI) |=> nmi_req);

   assert_smi_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      smi_req |-> $past(tmr_fire || rise_a || rise_b));

   assert_fixed_post_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_fire && t_live && t_mode == DM_FIXED)
      |=> pend_vec[$past(e_tmr[VEC_W-1:0])]);

   assert_timer_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_fire && t_live && t_mode == DM_FIXED && !rise_a && !rise_b)
      |=> !trig_vec[$past(e_tmr[VEC_W-1:0])]);

   assert_level_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_a && a_mode == DM_FIXED && e_pina[LVL_BIT] && !tmr_fire && !rise_b)
      |=> (!pend_vec[$past(e_pina[VEC_W-1:0])] && !ext_req));

   assert_ext_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_a && a_mode == DM_EXTCTL && !tmr_fire && !rise_b) |=> !ext_req);
endmodule

bind lvd_dispatch lvd_checker #(.VEC_W(VEC_W), .ENTRY_W(ENTRY_W)) u_lvd_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tmr_fire (tmr_fire),
   .rise_a   (pina_rise),
   .fall_a   (pina_fall),
   .rise_b   (pinb_rise),
   .e_tmr    (entry_q[0]),
   .e_pina   (entry_q[1]),
   .e_pinb   (entry_q[2]),
   .smi_req  (smi_req),
   .nmi_req  (nmi_req),
   .ext_req  (ext_req),
   .pend_vec (pend_vec),
   .trig_vec (trig_vec)
);

// File: tb/test_lvd_dispatch.sv
`timescale 1ns/1ps
module test_lvd_dispatch;
   localparam real CLK_HALF = 2.5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [1:0]   cfg_sel = 2'd0;
   logic [31:0]  cfg_wdata = '0;
   logic         tmr_fire = 1'b0;
   logic         lint0_pin = 1'b0;
   logic         lint1_pin = 1'b0;
   logic         smi_req, nmi_req, ext_req;
   logic [255:0] pend_vec, trig_vec;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0]  m_ent [3];
   logic [255:0] m_pend, m_trig;
   logic         m_ext, m_aq, m_bq;

   always #(CLK_HALF) clk = ~clk;

   lvd_dispatch i_lvd_dispatch (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .tmr_fire(tmr_fire), .lint0_pin(lint0_pin),
      .lint1_pin(lint1_pin), .smi_req(smi_req), .nmi_req(nmi_req),
      .ext_req(ext_req), .pend_vec(pend_vec), .trig_vec(trig_vec)
   );

   function automatic logic [31:0] mk(bit msk, bit lv, logic [2:0] md, logic [7:0] v);
      return {15'd0, msk, lv, 4'd0, md, v};
   endfunction

   task automatic cmp1(string tag, string what, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   task automatic cmpw(string tag, string what, logic [255:0] act, logic [255:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Drive one cycle of stimulus, predict, then compare after the edge.
   task automatic step(string tag, bit t, bit pa, bit pb,
                       bit we = 0, logic [1:0] sel = 0, logic [31:0] wd = 0);
      logic [2:0]   fire;
      logic [255:0] n_pend, n_trig, setm, lvlm;
      logic         e_smi, e_nmi, e_ext, set_ext, drop;
      logic         fall_a;
      cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
      tmr_fire = t; lint0_pin = pa; lint1_pin = pb;
      fire = {pb & ~m_bq, pa & ~m_aq, t};
      fall_a = ~pa & m_aq;
      n_pend = m_pend; n_trig = m_trig; setm = '0; lvlm = '0;
      e_smi = 0; e_nmi = 0; set_ext = 0; drop = 0;
      if (fall_a && m_ent[1][10:8] == 3'b000 && m_ent[1][15]) begin
         n_pend[m_ent[1][7:0]] = 1'b0;
         drop = 1;
      end
      if (fall_a && m_ent[1][10:8] == 3'b111) drop = 1;
      for (int s = 0; s < 3; s++) begin
         if (fire[s] && !m_ent[s][16]) begin
            case (m_ent[s][10:8])
               3'b000: begin
                  setm[m_ent[s][7:0]] = 1'b1;
                  if (s != 0 && m_ent[s][15]) lvlm[m_ent[s][7:0]] = 1'b1;
               end
               3'b010: e_smi = 1;
               3'b100: e_nmi = 1;
               3'b111: set_ext = 1;
               default: ;
            endcase
         end
      end
      n_pend = n_pend | setm;
      n_trig = (n_trig & ~setm) | lvlm;
      e_ext = set_ext ? 1'b1 : (drop ? 1'b0 : m_ext);
      @(posedge clk);
      @(negedge clk);
      cmpw(tag, "pend_vec", pend_vec, n_pend);
      cmpw(tag, "trig_vec", trig_vec, n_trig);
      cmp1(tag, "smi_req", smi_req, e_smi);
      cmp1(tag, "nmi_req", nmi_req, e_nmi);
      cmp1(tag, "ext_req", ext_req, e_ext);
      m_pend = n_pend; m_trig = n_trig; m_ext = e_ext;
      m_aq = pa; m_bq = pb;
      if (we) m_ent[sel] = wd;
   endtask

   initial begin
      #(CLK_HALF * 2.0 * 200000.0);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      m_ent[0] = 32'h0001_0000; m_ent[1] = 32'h0000_0700; m_ent[2] = 32'h0001_0000;
      m_pend = '0; m_trig = '0; m_ext = 0; m_aq = 0; m_bq = 0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state of outputs
      cmpw("R9", "pend_vec", pend_vec, '0);
      cmpw("R9", "trig_vec", trig_vec, '0);
      cmp1("R9", "smi_req", smi_req, 0);
      cmp1("R9", "nmi_req", nmi_req, 0);
      cmp1("R9", "ext_req", ext_req, 0);

      step("R1", 1, 0, 0);              // timer entry masked at reset
      step("R9", 0, 1, 0);              // pin A reset entry is external mode
      cmp1("R9", "ext after pin A rise", ext_req, 1);
      step("R8", 0, 0, 0);              // external mode fall drops ext
      cmp1("R8", "ext after pin A fall", ext_req, 0);

      step("R5", 0, 0, 0, 1, 2'd0, mk(0, 0, 3'b000, 8'h21));
      step("R5", 1, 0, 0);
      step("R6", 0, 0, 0, 1, 2'd0, mk(0, 1, 3'b000, 8'h22));
      step("R6", 1, 0, 0);              // level bit ignored on timer
      step("R6", 0, 0, 0, 1, 2'd2, mk(0, 1, 3'b000, 8'h40));
      step("R6", 0, 0, 1);
      step("R6", 0, 0, 0);

      step("R7", 0, 0, 0, 1, 2'd1, mk(0, 1, 3'b000, 8'h55));
      step("R7", 0, 1, 0);
      step("R7", 0, 0, 0);
      cmp1("R7", "pend 0x55 withdrawn", pend_vec[8'h55], 0);
      step("R8", 0, 0, 0, 1, 2'd1, mk(0, 0, 3'b000, 8'h56));
      step("R8", 0, 1, 0);
      step("R8", 0, 0, 0);
      cmp1("R8", "edge pend 0x56 kept", pend_vec[8'h56], 1);
      step("R7", 0, 0, 0, 1, 2'd1, mk(1, 1, 3'b000, 8'h56));
      step("R7", 0, 1, 0);              // masked: no post
      step("R7", 0, 0, 0);              // fall still clears
      cmp1("R7", "masked fall clears 0x56", pend_vec[8'h56], 0);

      step("R3", 0, 0, 0, 1, 2'd0, mk(0, 0, 3'b010, 8'h00));
      step("R3", 1, 0, 0);
      step("R3", 0, 0, 0);
      step("R3", 0, 0, 0, 1, 2'd2, mk(0, 0, 3'b100, 8'h00));
      step("R11", 0, 0, 1);
      step("R11", 0, 0, 1);             // held pin: no second pulse
      cmp1("R11", "nmi once on held pin", nmi_req, 0);
      step("R2", 0, 0, 0, 1, 2'd0, mk(0, 0, 3'b001, 8'h30));
      step("R2", 1, 0, 0);
      step("R2", 0, 0, 0, 1, 2'd0, mk(0, 0, 3'b110, 8'h31));
      step("R2", 1, 0, 0);

      step("R11", 0, 0, 0, 1, 2'd0, mk(0, 0, 3'b000, 8'h70));
      step("R11", 1, 0, 0, 1, 2'd0, mk(0, 0, 3'b100, 8'h00));
      cmp1("R11", "old entry used", pend_vec[8'h70], 1);

      step("R10", 0, 0, 0, 1, 2'd0, mk(0, 0, 3'b000, 8'h60));
      step("R10", 0, 0, 0, 1, 2'd2, mk(0, 1, 3'b000, 8'h60));
      step("R10", 1, 0, 1);
      cmp1("R10", "level wins same vector", trig_vec[8'h60], 1);
      step("R10", 0, 0, 0, 1, 2'd0, mk(0, 0, 3'b111, 8'h00));
      step("R10", 0, 0, 0, 1, 2'd1, mk(0, 0, 3'b111, 8'h00));
      step("R4", 0, 1, 0);
      step("R10", 1, 0, 0);             // set beats withdrawal
      cmp1("R10", "ext set wins", ext_req, 1);

      for (int k = 0; k < 3000; k++) begin
         logic [2:0] md;
         logic [2:0] pick = 3'($urandom_range(0, 4));
         md = (pick == 0) ? 3'b000 : (pick == 1) ? 3'b010 : (pick == 2) ? 3'b100 :
              (pick == 3) ? 3'b111 : 3'b001;
         if ($urandom_range(0, 1) == 0) md = 3'b000;
         step("R10", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
              2'($urandom_range(0, 2)),
              mk(($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)), md,
                 8'h10 + 8'($urandom_range(0, 7))));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule